// File: doc/BRIEF.md
# Auxiliary Stereo I2S Port with Master/Slave Clocking

This block is a secondary stereo serial-audio port that sits beside a multichannel time-division serial port. It collects two I2S data streams from external converters and returns one I2S stream to an external DAC. Both directions share one bit clock and one word clock. The block can run in one of two clock modes. In master mode it derives both clocks from the master clock and drives them out. In slave mode it follows clocks that arrive from outside. The mode is set by a single control bit held in the configuration registers.

All logic runs on the master clock. In slave mode the external clocks and data pass through a synchroniser chain, and their edges are found by comparing against delayed copies. A frame starts when the word clock falls, which is also where the left channel begins. At each frame start the block gives a one-cycle sync pulse. The surrounding converter logic uses this pulse to realign its sample-frame counter.

The clock pins are split into an input, an output and an output-enable, so the pad ring can build the bidirectional pin. Samples are carried MSB first, with SAMPLE_W bits in each SLOT_W-bit half-frame.

Top module: `aux_i2s_port`

## Requirements
- R1: With `mst_sel`=1, `bclk_oe` is 1 and `bclk_o` has a period of MCLK_PER_BCLK master clocks, with equal high and low halves (default 8 clocks).
- R2: With `mst_sel`=1, `lrclk_o` has a period of 2·SLOT_W·MCLK_PER_BCLK master clocks (default 512). It changes only in the cycle where `bclk_o` falls.
- R3: With `mst_sel`=0, both output enables are 0, and all framing and data timing follows `bclk_i` and `lrclk_i`.
- R4: `sync_o` is high for exactly one cycle for each falling edge of the active word clock, and never on a rising edge. In master mode it is high in the cycle after `lrclk_o` falls.
- R5: Received format: word clock low selects the left channel and high selects the right channel. The MSB is the bit sampled on the second rising bit-clock edge after a word-clock change, and SAMPLE_W bits follow MSB first. All other bits of the slot are ignored.
- R6: `rx_valid` pulses for one cycle after the last data bit of the right slot is sampled. Lane i delivers its left and right words of that same frame on bits [i·SAMPLE_W +: SAMPLE_W] of `rx_left` and `rx_right`.
- R7: `rx_valid` stays low until a full left-plus-right frame has been received after the first word-clock falling edge following reset.
- R8: Transmitted format: `sdo` changes only after a falling bit-clock edge. It carries the left word while the word clock is low and the right word while it is high, MSB first, starting on the bit after the word-clock change. All other bits of the slot are 0.
- R9: `tx_left` and `tx_right` are captured at each word-clock falling edge. A change to them later in the frame affects only the next frame.
- R10: While `rst_n` is low, `bclk_o`, `lrclk_o`, `sdo`, `rx_valid`, `sync_o`, `rx_left` and `rx_right` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every register uses it |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_sel | input | 1 | 1 = generate the port clocks, 0 = follow external clocks |
| bclk_i | input | 1 | External bit clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| bclk_oe | output | 1 | Pad enable for the bit-clock pin |
| lrclk_i | input | 1 | External word clock (slave mode) |
| lrclk_o | output | 1 | Generated word clock (master mode) |
| lrclk_oe | output | 1 | Pad enable for the word-clock pin |
| sdi | input | LANES | Serial data from the external ADCs, one bit per lane |
| sdo | output | 1 | Serial data to the external DAC |
| tx_left | input | SAMPLE_W | Left word to transmit |
| tx_right | input | SAMPLE_W | Right word to transmit |
| rx_left | output | LANES·SAMPLE_W | Received left words, lane 0 in the low bits |
| rx_right | output | LANES·SAMPLE_W | Received right words, lane 0 in the low bits |
| rx_valid | output | 1 | One-cycle strobe marking a new received pair |
| sync_o | output | 1 | Frame-start pulse for realigning the sample-frame counter |

## Verification
The bench builds the port with 6-bit samples, 8-bit slots, a 4:1 clock divider, two lanes and two synchroniser stages. This makes a master-mode frame 64 clocks long. Because the sample width is 6 bits, each of the 64 possible transmit words can be sent through the left channel in one sweep. The same frames carry arithmetic patterns on both receive lanes, with 1s in every padding bit to show that those bits are ignored. A second pass runs in slave mode with slower bench-driven clocks, so the sync-chain delay is covered while the same per-frame checks run.

// File: rtl/aux_i2s_pkg.sv
`timescale 1ns/1ps
package aux_i2s_pkg;

   // edge events of the active port clocks, seen in the master-clock domain
   typedef struct packed {
      logic lr;        // current word-clock level
      logic b_rise;    // bit clock rose
      logic b_fall;    // bit clock fell
      logic lr_fall;   // word clock fell (left channel / frame start)
   } aux_edge_t;

endpackage

// File: rtl/aux_i2s_clk.sv
`timescale 1ns/1ps
module aux_i2s_clk
   import aux_i2s_pkg::*;
#(
   parameter int unsigned MCLK_PER_BCLK = 8,
   parameter int unsigned SLOT_W        = 32,
   parameter int unsigned LANES         = 2,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mst_sel,
   input  logic             bclk_i,
   input  logic             lrclk_i,
   input  logic [LANES-1:0] sdi_i,
   output logic             bclk_m,
   output logic             lrclk_m,
   output aux_edge_t        ev,
   output logic [LANES-1:0] sdi_s
);
   localparam int unsigned FRAME_MCLK = 2 * SLOT_W * MCLK_PER_BCLK;
   localparam int unsigned CNT_W      = $clog2(FRAME_MCLK);
   localparam int unsigned BCLK_BIT   = $clog2(MCLK_PER_BCLK) - 1;
   localparam int unsigned NSIG       = LANES + 2;
   localparam int unsigned CHAIN_W    = SYNC_STAGES * NSIG;

   if (MCLK_PER_BCLK < 2 || (MCLK_PER_BCLK & (MCLK_PER_BCLK - 1)) != 0) begin : g_bad_div
      $error("MCLK_PER_BCLK must be a power of two, at least 2");
   end
   if (SLOT_W < 2 || (SLOT_W & (SLOT_W - 1)) != 0) begin : g_bad_slot
      $error("SLOT_W must be a power of two, at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // master-mode divider: one counter period is one word-clock frame
   logic [CNT_W-1:0] div_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) div_cnt <= '0;
      else        div_cnt <= div_cnt + 1'b1;
   end
   assign bclk_m  = div_cnt[BCLK_BIT];
   assign lrclk_m = div_cnt[CNT_W-1];

   // slave-mode synchroniser: clocks and data travel together, same delay
   logic [CHAIN_W-1:0] chain;
   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CHAIN_W-NSIG-1:0], sdi_i, lrclk_i, bclk_i};
   end
   logic [NSIG-1:0] tail;
   assign tail = chain[CHAIN_W-1 -: NSIG];

   logic b_int, l_int, b_q, l_q;
   always_comb begin
      b_int = mst_sel ? bclk_m  : tail[0];
      l_int = mst_sel ? lrclk_m : tail[1];
      sdi_s = mst_sel ? sdi_i   : tail[NSIG-1:2];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_q <= 1'b0;
         l_q <= 1'b0;
      end else begin
         b_q <= b_int;
         l_q <= l_int;
      end
   end

   always_comb begin
      ev.lr      = l_int;
      ev.b_rise  = b_int & ~b_q;
      ev.b_fall  = ~b_int & b_q;
      ev.lr_fall = ~l_int & l_q;
   end

   // R2
   lr_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_sel && !$stable(lrclk_m)) |-> $fell(bclk_m));

endmodule

// File: rtl/aux_i2s_slot.sv
`timescale 1ns/1ps
module aux_i2s_slot
   import aux_i2s_pkg::*;
#(
   parameter int unsigned SLOT_W = 32,
   parameter int unsigned PW     = $clog2(SLOT_W) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  aux_edge_t     ev,
   output logic [PW-1:0] rpos,
   output logic [PW-1:0] tpos,
   output logic          aligned
);
   localparam logic [PW-1:0] LAST = PW'(SLOT_W);

   logic [PW-1:0] rpos_q, tpos_q;
   logic          lr_r, lr_t;

   // position of the bit at this edge; 0 is the bit right after a word-clock change
   always_comb begin
      rpos = (ev.lr != lr_r) ? '0 : ((rpos_q == LAST) ? LAST : rpos_q + 1'b1);
      tpos = (ev.lr != lr_t) ? '0 : ((tpos_q == LAST) ? LAST : tpos_q + 1'b1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rpos_q  <= '0;
         tpos_q  <= '0;
         lr_r    <= 1'b0;
         lr_t    <= 1'b0;
         aligned <= 1'b0;
      end else begin
         if (ev.b_rise) begin
            rpos_q <= rpos;
            lr_r   <= ev.lr;
         end
         if (ev.b_fall) begin
            tpos_q <= tpos;
            lr_t   <= ev.lr;
         end
         if (ev.lr_fall) aligned <= 1'b1;
      end
   end

endmodule

// File: rtl/aux_i2s_rx_lane.sv
`timescale 1ns/1ps
module aux_i2s_rx_lane #(
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned PW       = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample,
   input  logic                lr,
   input  logic [PW-1:0]       pos,
   input  logic                sdi,
   output logic [SAMPLE_W-1:0] left,
   output logic [SAMPLE_W-1:0] right
);
   logic [SAMPLE_W-1:0] shreg, lhold, word_now;
   logic                in_word, last_bit;

   always_comb begin
      word_now = {shreg[SAMPLE_W-2:0], sdi};
      in_word  = (pos >= PW'(1)) && (pos <= PW'(SAMPLE_W));
      last_bit = (pos == PW'(SAMPLE_W));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         lhold <= '0;
         left  <= '0;
         right <= '0;
      end else if (sample && in_word) begin
         shreg <= word_now;
         if (last_bit) begin
            if (!lr) begin
               lhold <= word_now;
            end else begin
               left  <= lhold;
               right <= word_now;
            end
         end
      end
   end

endmodule

// File: rtl/aux_i2s_tx.sv
`timescale 1ns/1ps
module aux_i2s_tx #(
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned PW       = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lr,
   input  logic                b_fall,
   input  logic                lr_fall,
   input  logic [PW-1:0]       tpos,
   input  logic [SAMPLE_W-1:0] tx_left,
   input  logic [SAMPLE_W-1:0] tx_right,
   output logic                sdo
);
   logic [SAMPLE_W-1:0] l_q, r_q, word;
   logic                nxt;

   always_comb begin
      word = lr ? r_q : l_q;
      nxt  = 1'b0;
      for (int i = 0; i < int'(SAMPLE_W); i++) begin
         if (tpos == PW'(int'(SAMPLE_W) - i)) nxt = word[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         l_q <= '0;
         r_q <= '0;
         sdo <= 1'b0;
      end else begin
         if (lr_fall) begin
            l_q <= tx_left;
            r_q <= tx_right;
         end
         if (b_fall) sdo <= nxt;
      end
   end

   // R8
   tx_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_fall && tpos == '0) |=> !sdo);

endmodule

// File: rtl/aux_i2s_port.sv
`timescale 1ns/1ps
module aux_i2s_port
   import aux_i2s_pkg::*;
#(
   parameter int unsigned SAMPLE_W      = 24,
   parameter int unsigned SLOT_W        = 32,
   parameter int unsigned MCLK_PER_BCLK = 8,
   parameter int unsigned LANES         = 2,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mst_sel,
   input  logic                      bclk_i,
   output logic                      bclk_o,
   output logic                      bclk_oe,
   input  logic                      lrclk_i,
   output logic                      lrclk_o,
   output logic                      lrclk_oe,
   input  logic [LANES-1:0]          sdi,
   output logic                      sdo,
   input  logic [SAMPLE_W-1:0]       tx_left,
   input  logic [SAMPLE_W-1:0]       tx_right,
   output logic [LANES*SAMPLE_W-1:0] rx_left,
   output logic [LANES*SAMPLE_W-1:0] rx_right,
   output logic                      rx_valid,
   output logic                      sync_o
);
   localparam int unsigned PW = $clog2(SLOT_W) + 1;

   if (SAMPLE_W < 2 || SAMPLE_W >= SLOT_W) begin : g_bad_width
      $error("SAMPLE_W must be at least 2 and below SLOT_W");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   aux_edge_t        ev;
   logic [LANES-1:0] sdi_s;
   logic [PW-1:0]    rpos, tpos;
   logic             aligned;

   aux_i2s_clk #(
      .MCLK_PER_BCLK(MCLK_PER_BCLK), .SLOT_W(SLOT_W),
      .LANES(LANES), .SYNC_STAGES(SYNC_STAGES)
   ) clk_i (
      .clk(clk), .rst_n(rst_n), .mst_sel(mst_sel),
      .bclk_i(bclk_i), .lrclk_i(lrclk_i), .sdi_i(sdi),
      .bclk_m(bclk_o), .lrclk_m(lrclk_o), .ev(ev), .sdi_s(sdi_s)
   );

   assign bclk_oe  = mst_sel;
   assign lrclk_oe = mst_sel;

   aux_i2s_slot #(.SLOT_W(SLOT_W), .PW(PW)) slot_i (
      .clk(clk), .rst_n(rst_n), .ev(ev),
      .rpos(rpos), .tpos(tpos), .aligned(aligned)
   );

   for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
      aux_i2s_rx_lane #(.SAMPLE_W(SAMPLE_W), .PW(PW)) rx_i (
         .clk(clk), .rst_n(rst_n), .sample(ev.b_rise), .lr(ev.lr),
         .pos(rpos), .sdi(sdi_s[g]),
         .left(rx_left[g*SAMPLE_W +: SAMPLE_W]),
         .right(rx_right[g*SAMPLE_W +: SAMPLE_W])
      );
   end

   aux_i2s_tx #(.SAMPLE_W(SAMPLE_W), .PW(PW)) tx_i (
      .clk(clk), .rst_n(rst_n), .lr(ev.lr), .b_fall(ev.b_fall),
      .lr_fall(ev.lr_fall), .tpos(tpos),
      .tx_left(tx_left), .tx_right(tx_right), .sdo(sdo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_valid <= 1'b0;
         sync_o   <= 1'b0;
      end else begin
         rx_valid <= aligned && ev.b_rise && ev.lr && (rpos == PW'(SAMPLE_W));
         sync_o   <= ev.lr_fall;
      end
   end

   // checker state: a frame start has been announced since reset
   logic seen_sync;
   always_ff @(posedge clk) begin
      if (!rst_n)      seen_sync <= 1'b0;
      else if (sync_o) seen_sync <= 1'b1;
   end

   // R4
   sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |=> !sync_o);

   // R4
   sync_after_lr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_sel && $past(mst_sel) && $fell(lrclk_o)) |=> sync_o);

   // R6
   rx_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R7
   rx_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> seen_sync);

endmodule

// File: tb/aux_i2s_port_tb_top.sv
`timescale 1ns/1ps
module aux_i2s_port_tb_top;
   localparam int W     = 6;
   localparam int SLOT  = 8;
   localparam int DIV   = 4;
   localparam int LN    = 2;
   localparam int SS    = 2;
   localparam int FRAME = 2 * SLOT * DIV;
   localparam int HALF  = 6;

   logic            clk, rst_n, mst_sel;
   logic            bclk_drv, lrclk_drv;
   logic            bclk_o, bclk_oe, lrclk_o, lrclk_oe;
   logic [LN-1:0]   sdi;
   logic            sdo, rx_valid, sync_o;
   logic [W-1:0]    tx_left, tx_right;
   logic [LN*W-1:0] rx_left, rx_right;

   aux_i2s_port #(
      .SAMPLE_W(W), .SLOT_W(SLOT), .MCLK_PER_BCLK(DIV), .LANES(LN), .SYNC_STAGES(SS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .mst_sel(mst_sel),
      .bclk_i(bclk_drv), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
      .lrclk_i(lrclk_drv), .lrclk_o(lrclk_o), .lrclk_oe(lrclk_oe),
      .sdi(sdi), .sdo(sdo), .tx_left(tx_left), .tx_right(tx_right),
      .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid), .sync_o(sync_o)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   int n_run = 0, n_fail = 0;
   bit done = 0, active = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] rxv(input int lane, input logic ch, input int k);
      int v;
      if (lane == 0) v = ch ? (63 - k) : k;
      else           v = ch ? (k ^ 42) : (k * 5 + 1);
      return W'(v);
   endfunction

   function automatic logic [W-1:0] txv(input logic ch, input int k);
      return ch ? W'(k * 7 + 3) : W'(k);
   endfunction

   // engine state
   int   cyc, scnt, sb, k, tk, tpos, rpos, pk, bdel;
   int   last_br, last_lf, nsync, nlf, nvalid;
   bit   prev_b, prev_l, lt, lr_r, fstart, pend_fresh, tx_ok, sync_exp, b, l;
   logic [W-1:0] dec, decL, expL, expR, tmp;

   task automatic eng_clear();
      cyc = 0; scnt = 0; sb = 0; k = -1; tk = 0; tpos = 0; rpos = 0; pk = 0; bdel = 0;
      last_br = -1; last_lf = -1; nsync = 0; nlf = 0; nvalid = 0;
      prev_b = 0; prev_l = 0; lt = 0; lr_r = 0; fstart = 0; pend_fresh = 0;
      tx_ok = 0; sync_exp = 0; dec = '0; decL = '0; expL = '0; expR = '0;
   endtask

   // stimulus and model engine, stepping on the falling master-clock edge
   initial begin
      eng_clear();
      forever begin
         @(negedge clk);
         if (active) begin
            if (!mst_sel) begin
               scnt++;
               if (scnt == HALF) begin
                  scnt = 0;
                  bclk_drv = ~bclk_drv;
                  if (!bclk_drv) begin
                     sb++;
                     if (sb == SLOT) begin
                        sb = 0;
                        lrclk_drv = ~lrclk_drv;
                     end
                  end
               end
            end
            b = mst_sel ? bclk_o  : bclk_drv;
            l = mst_sel ? lrclk_o : lrclk_drv;
            cyc++;

            // transmit words: capture expectation at frame start, then disturb, then set next
            if (sync_o) begin
               nsync++;
               expL = tx_left; expR = tx_right; tx_ok = 1;
               tk++;
               tx_left  = W'(tk * 13 + 5);
               tx_right = ~tx_left;
               bdel = 7;
            end else if (bdel > 0) begin
               bdel--;
               if (bdel == 0) begin
                  tx_left  = txv(1'b0, tk);
                  tx_right = txv(1'b1, tk);
               end
            end

            // R4: sync pulse one cycle after the generated word clock falls
            if (mst_sel && (sync_o || sync_exp))
               chk(sync_o == sync_exp, "R4 sync timing", int'(sync_o), int'(sync_exp));
            sync_exp = mst_sel && prev_l && !l;

            // R5 / R6 / R7: received pairs
            if (rx_valid) begin
               nvalid++;
               chk(pend_fresh, "R7 early or extra rx_valid", 1, int'(pend_fresh));
               if (pend_fresh) begin
                  chk(rx_left[0 +: W]  == rxv(0, 1'b0, pk), "R5 lane0 left",  int'(rx_left[0 +: W]),  int'(rxv(0, 1'b0, pk)));
                  chk(rx_right[0 +: W] == rxv(0, 1'b1, pk), "R5 lane0 right", int'(rx_right[0 +: W]), int'(rxv(0, 1'b1, pk)));
                  chk(rx_left[W +: W]  == rxv(1, 1'b0, pk), "R6 lane1 left",  int'(rx_left[W +: W]),  int'(rxv(1, 1'b0, pk)));
                  chk(rx_right[W +: W] == rxv(1, 1'b1, pk), "R6 lane1 right", int'(rx_right[W +: W]), int'(rxv(1, 1'b1, pk)));
               end
               pend_fresh = 0;
            end

            // bit-clock falling: bench converters present the next bit
            if (prev_b && !b) begin
               if (mst_sel && last_br >= 0)
                  chk(cyc - last_br == DIV / 2, "R1 bclk high time", cyc - last_br, DIV / 2);
               if (l != lt) begin
                  tpos = 0; lt = l;
                  if (!l) begin k++; fstart = 1; end
               end else if (tpos < SLOT) tpos++;
               for (int i = 0; i < LN; i++) begin
                  tmp = rxv(i, l, k);
                  sdi[i] = (fstart && tpos >= 1 && tpos <= W) ? tmp[W - tpos] : 1'b1;
               end
               if (fstart && l && tpos == W) begin
                  if (pend_fresh) chk(1'b0, "R6 missing rx_valid", 0, 1);
                  pk = k; pend_fresh = 1;
               end
            end

            // bit-clock rising: decode the DAC stream
            if (!prev_b && b) begin
               if (mst_sel) begin
                  chk(bclk_oe == 1'b1, "R1 bclk_oe", int'(bclk_oe), 1);
                  if (last_br >= 0)
                     chk(cyc - last_br == DIV, "R1 bclk period", cyc - last_br, DIV);
               end
               last_br = cyc;
               if (l != lr_r) begin rpos = 0; lr_r = l; end
               else if (rpos < SLOT) rpos++;
               if (rpos == 0 || rpos > W)
                  chk(sdo == 1'b0, "R8 padding bit", int'(sdo), 0);
               if (rpos >= 1 && rpos <= W) dec = {dec[W-2:0], sdo};
               if (rpos == W) begin
                  if (!l) decL = dec;
                  else if (tx_ok) begin
                     chk(decL == expL, "R8 left word",  int'(decL), int'(expL));
                     chk(dec  == expR, "R9 right word", int'(dec),  int'(expR));
                  end
               end
            end

            // word-clock edges
            if (l != prev_l && mst_sel)
               chk(prev_b && !b, "R2 lrclk moves with bclk fall", int'(b), 0);
            if (prev_l && !l) begin
               nlf++;
               if (mst_sel && last_lf >= 0)
                  chk(cyc - last_lf == FRAME, "R2 lrclk period", cyc - last_lf, FRAME);
               last_lf = cyc;
            end

            prev_b = b;
            prev_l = l;
         end
      end
   end

   task automatic reset_phase(input logic mst);
      @(negedge clk);
      active    = 0;
      rst_n     = 1'b0;
      mst_sel   = mst;
      bclk_drv  = 1'b0;
      lrclk_drv = 1'b0;
      sdi       = '1;
      tx_left   = txv(1'b0, 0);
      tx_right  = txv(1'b1, 0);
      eng_clear();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; mst_sel = 1'b1; bclk_drv = 1'b0; lrclk_drv = 1'b0; sdi = '1;
      tx_left = '0; tx_right = '0;

      // master pass
      reset_phase(1'b1);
      // R10 reset state
      chk(bclk_o == 1'b0 && lrclk_o == 1'b0, "R10 clocks in reset", int'({bclk_o, lrclk_o}), 0);
      chk(sdo == 1'b0 && rx_valid == 1'b0 && sync_o == 1'b0, "R10 strobes in reset",
          int'({sdo, rx_valid, sync_o}), 0);
      chk(rx_left == '0 && rx_right == '0, "R10 rx words in reset", int'(rx_left | rx_right), 0);
      chk(bclk_oe == 1'b1 && lrclk_oe == 1'b1, "R1 enables in master", int'({bclk_oe, lrclk_oe}), 3);
      rst_n  = 1'b1;
      active = 1;
      while (tk < 66) @(negedge clk);
      chk(nvalid >= 60, "R6 master pair count", nvalid, 60);

      // slave pass
      reset_phase(1'b0);
      chk(bclk_oe == 1'b0 && lrclk_oe == 1'b0, "R3 enables in slave", int'({bclk_oe, lrclk_oe}), 0);
      rst_n  = 1'b1;
      active = 1;
      while (tk < 20) @(negedge clk);
      chk(nsync == nlf, "R4 slave sync per falling edge", nsync, nlf);
      chk(nvalid >= 17, "R3 slave pair count", nvalid, 17);
      active = 0;

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule